// File: doc/BRIEF.md
# Two-Stage Encoded Clock Divider

This block divides a fast input clock by two cascaded ratios. The first stage
uses a high-speed ratio picked by a 3-bit code from a sparse set of values. The
second stage divides the first stage's wrap events by a ratio that comes from a
7-bit code holding the ratio minus one. Both codes are decoded with fixed
rounding rules. Unused high-speed codes fall back to the largest ratio and set a
sticky error flag. Odd second-stage ratios above one are raised to the next even
value.

The codes are sampled only when an apply strobe is seen while freeze is low. On
that edge both counter stages restart together from phase zero. While freeze is
high, or while apply is low, the code inputs may change freely and the running
output keeps its pattern. The output is a registered level whose period is the
product of the two decoded ratios.

Top module: `dual_stage_clkdiv`

## Requirements
- R1: High-speed code decoding: 3'b000 selects 4, 3'b001 selects 5, 3'b010 selects 6, 3'b011 selects 7, 3'b101 selects 9 and 3'b111 selects 11. The output period is the high-speed ratio times the second-stage ratio, in input clock cycles.
- R2: The second-stage ratio is the 7-bit code plus one, so code 0 divides by 1 and code 127 divides by 128.
- R3: When code plus one is odd and above 1, the second-stage ratio is raised by one to the next even value. For example, code 2 divides by 4.
- R4: The unused high-speed codes 3'b100 and 3'b110 divide by 11.
- R5: code_err_o goes high on the edge that accepts a load carrying an unused high-speed code. It then stays high until reset. A load that is not accepted never sets it.
- R6: With a second-stage ratio of 1, the output is high for the first ceil(HS/2) cycles of each period and low for the rest. With a larger ratio, it is high for the first half of the period, HS*N1/2 cycles.
- R7: New codes are taken only on a clock edge where apply_i is high and freeze_i is low. If apply_i rises while freeze is high, or if the codes change without apply, the output pattern is undisturbed.
- R8: After an accepted load, both stages restart at phase zero. The output is high in the cycle after the load edge, and the new pattern starts from there.
- R9: Reset is asynchronous and active-low. It applies the reset codes, which default to divide by 4 then by 1. It holds the output high at phase zero and clears code_err_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast input clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| hs_code_i | input | 3 | High-speed ratio code |
| n1_code_i | input | N1_CODE_W | Second-stage code (ratio minus one) |
| apply_i | input | 1 | Load strobe for both codes |
| freeze_i | input | 1 | Blocks loads while high |
| clk_o | output | 1 | Divided output level |
| code_err_o | output | 1 | Sticky flag for an accepted unused high-speed code |

## Verification
A wrong ratio register or a wrong counter state shows on clk_o within one output
period. It appears as an edge at the wrong cycle count, so the bench compares
every cycle of two whole periods against a phase computed from the decoded
ratios. A restart that fails to clear either stage shows at once: the first cycle
after the load is low, or the first falling edge lands at the wrong place. A
decode or flag fault shows on code_err_o in the cycle after the load edge.
Freeze and no-apply faults appear as a phase jump in a pattern that should run on
unchanged.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
    localparam int HS_CODE_W  = 3;
    localparam int HS_RATIO_W = 4;

    // Sparse high-speed ratio set; holes fall back to the largest ratio.
    function automatic logic [HS_RATIO_W-1:0] hs_ratio_f(input logic [HS_CODE_W-1:0] code);
        case (code)
            3'b000:  hs_ratio_f = 4'd4;
            3'b001:  hs_ratio_f = 4'd5;
            3'b010:  hs_ratio_f = 4'd6;
            3'b011:  hs_ratio_f = 4'd7;
            3'b101:  hs_ratio_f = 4'd9;
            default: hs_ratio_f = 4'd11;
        endcase
    endfunction

    function automatic logic hs_unused_f(input logic [HS_CODE_W-1:0] code);
        hs_unused_f = (code == 3'b100) || (code == 3'b110);
    endfunction
endpackage

// File: rtl/n1_decode.sv
module n1_decode #(
    parameter int CODE_W  = 7,
    localparam int RATIO_W = CODE_W + 1
) (
    input  logic [CODE_W-1:0]  code_i,
    output logic [RATIO_W-1:0] ratio_o
);
    logic [RATIO_W-1:0] plus_one;

    always_comb begin
        plus_one = {1'b0, code_i} + RATIO_W'(1);
        // code even and nonzero -> odd ratio above one -> raise to even
        if (code_i != '0 && !code_i[0]) begin
            ratio_o = plus_one + RATIO_W'(1);
        end else begin
            ratio_o = plus_one;
        end
    end
endmodule

// File: rtl/wrap_counter.sv
module wrap_counter #(
    parameter int W = 4
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         restart_i,
    input  logic         adv_i,
    input  logic [W-1:0] ratio_i,
    output logic [W-1:0] cnt_d_o,
    output logic         wrap_o
);
    logic [W-1:0] cnt_d, cnt_q;
    logic         at_end;

    always_comb begin
        at_end = (cnt_q == ratio_i - W'(1));
        wrap_o = adv_i && !restart_i && at_end;
        cnt_d  = cnt_q;
        if (restart_i) begin
            cnt_d = '0;
        end else if (adv_i) begin
            cnt_d = at_end ? '0 : cnt_q + W'(1);
        end
        cnt_d_o = cnt_d;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end
endmodule

// File: rtl/dual_stage_clkdiv.sv
module dual_stage_clkdiv
    import clkdiv_pkg::*;
#(
    parameter int N1_CODE_W = 7,
    parameter logic [HS_CODE_W-1:0] RST_HS_CODE = 3'b000,
    parameter logic [N1_CODE_W-1:0] RST_N1_CODE = '0,
    localparam int N1_RATIO_W = N1_CODE_W + 1
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic [HS_CODE_W-1:0] hs_code_i,
    input  logic [N1_CODE_W-1:0] n1_code_i,
    input  logic                 apply_i,
    input  logic                 freeze_i,
    output logic                 clk_o,
    output logic                 code_err_o
);
    typedef struct packed {
        logic [HS_RATIO_W-1:0] hs_ratio;
        logic [N1_RATIO_W-1:0] n1_ratio;
        logic                  err;
        logic                  out;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic                  load;
    logic [N1_RATIO_W-1:0] n1_live, n1_rst;
    logic [HS_RATIO_W-1:0] hs_cnt_d, half_hs;
    logic [N1_RATIO_W-1:0] n1_cnt_d, half_n1;
    logic                  hs_wrap, n1_wrap_unused;
    logic [HS_RATIO_W-1:0] hs_ratio_w;
    logic [N1_RATIO_W-1:0] n1_ratio_w;

    assign load = apply_i && !freeze_i;

    n1_decode #(.CODE_W(N1_CODE_W)) u_dec_live (.code_i(n1_code_i),   .ratio_o(n1_live));
    n1_decode #(.CODE_W(N1_CODE_W)) u_dec_rst  (.code_i(RST_N1_CODE), .ratio_o(n1_rst));

    wrap_counter #(.W(HS_RATIO_W)) u_hs_stage (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .restart_i (load),
        .adv_i     (1'b1),
        .ratio_i   (ctl_q.hs_ratio),
        .cnt_d_o   (hs_cnt_d),
        .wrap_o    (hs_wrap)
    );

    wrap_counter #(.W(N1_RATIO_W)) u_n1_stage (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .restart_i (load),
        .adv_i     (hs_wrap),
        .ratio_i   (ctl_q.n1_ratio),
        .cnt_d_o   (n1_cnt_d),
        .wrap_o    (n1_wrap_unused)
    );

    always_comb begin
        ctl_d   = ctl_q;
        half_hs = (ctl_q.hs_ratio + HS_RATIO_W'(1)) >> 1;
        half_n1 = ctl_q.n1_ratio >> 1;
        if (load) begin
            ctl_d.hs_ratio = hs_ratio_f(hs_code_i);
            ctl_d.n1_ratio = n1_live;
            ctl_d.err      = ctl_q.err || hs_unused_f(hs_code_i);
        end
        // Counter next values are zero on a load, which always yields high.
        if (ctl_q.n1_ratio == N1_RATIO_W'(1)) begin
            ctl_d.out = (hs_cnt_d < half_hs);
        end else begin
            ctl_d.out = (n1_cnt_d < half_n1) || load;
        end
        if (load) ctl_d.out = 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ctl_q.hs_ratio <= hs_ratio_f(RST_HS_CODE);
            ctl_q.n1_ratio <= n1_rst;
            ctl_q.err      <= 1'b0;
            ctl_q.out      <= 1'b1;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign clk_o      = ctl_q.out;
    assign code_err_o = ctl_q.err;
    assign hs_ratio_w = ctl_q.hs_ratio;
    assign n1_ratio_w = ctl_q.n1_ratio;
endmodule

// File: rtl/dual_stage_clkdiv_chk.sv
module dual_stage_clkdiv_chk #(
    parameter int N1_CODE_W = 7,
    localparam int N1_RATIO_W = N1_CODE_W + 1
) (
    input logic                  clk_i,
    input logic                  rst_ni,
    input logic [2:0]            hs_code_i,
    input logic                  apply_i,
    input logic                  freeze_i,
    input logic                  clk_o,
    input logic                  code_err_o,
    input logic [3:0]            hs_ratio,
    input logic [N1_RATIO_W-1:0] n1_ratio
);
    p_hs_legal_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (hs_ratio == 4'd4) || (hs_ratio == 4'd5) || (hs_ratio == 4'd6) ||
        (hs_ratio == 4'd7) || (hs_ratio == 4'd9) || (hs_ratio == 4'd11));

    p_n1_even_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (n1_ratio == N1_RATIO_W'(1)) || !n1_ratio[0]);

    p_bad_code_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (apply_i && !freeze_i && (hs_code_i == 3'b100 || hs_code_i == 3'b110))
        |=> (hs_ratio == 4'd11) && code_err_o);

    p_err_sticky_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        code_err_o |=> code_err_o);

    p_frozen_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (freeze_i || !apply_i) |=> $stable(hs_ratio) && $stable(n1_ratio));

    p_restart_high_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (apply_i && !freeze_i) |=> clk_o);
endmodule

bind dual_stage_clkdiv dual_stage_clkdiv_chk #(.N1_CODE_W(N1_CODE_W)) u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .hs_code_i  (hs_code_i),
    .apply_i    (apply_i),
    .freeze_i   (freeze_i),
    .clk_o      (clk_o),
    .code_err_o (code_err_o),
    .hs_ratio   (hs_ratio_w),
    .n1_ratio   (n1_ratio_w)
);

// File: tb/tb_dual_stage_clkdiv.sv
`timescale 1ns/1ps
module tb_dual_stage_clkdiv;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG_CYCLES = 150000;

    logic       clk_i = 1'b0;
    logic       rst_ni = 1'b0;
    logic [2:0] hs_code_i = '0;
    logic [6:0] n1_code_i = '0;
    logic       apply_i = 1'b0;
    logic       freeze_i = 1'b0;
    logic       clk_o, code_err_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit bad_seen = 0;
    bit done     = 0;

    always #(CLK_PERIOD/2) clk_i = ~clk_i;

    dual_stage_clkdiv dut (
        .clk_i(clk_i), .rst_ni(rst_ni), .hs_code_i(hs_code_i), .n1_code_i(n1_code_i),
        .apply_i(apply_i), .freeze_i(freeze_i), .clk_o(clk_o), .code_err_o(code_err_o)
    );

    function automatic int exp_hs(input int c);
        case (c)
            0: return 4;
            1: return 5;
            2: return 6;
            3: return 7;
            5: return 9;
            default: return 11;
        endcase
    endfunction

    function automatic int exp_n1(input int c);
        int r = c + 1;
        if (r > 1 && (r % 2) == 1) r = r + 1;
        return r;
    endfunction

    function automatic int exp_out(input int hs, input int n1, input int p);
        int q = p % (hs * n1);
        if (n1 == 1) return (q < (hs + 1) / 2) ? 1 : 0;
        return ((q / hs) < (n1 / 2)) ? 1 : 0;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Samples at the current negedge for phases p0 .. p0+n-1, ends at phase p0+n.
    task automatic run_pattern(input int hs, input int n1, input int p0, input int n, input string req);
        for (int i = 0; i < n; i++) begin
            chk(clk_o == exp_out(hs, n1, p0 + i), req, clk_o, exp_out(hs, n1, p0 + i));
            @(negedge clk_i);
        end
    endtask

    // Leaves the bench at the negedge showing phase 0 of the new setting.
    task automatic do_apply(input int hc, input int nc);
        hs_code_i = 3'(hc);
        n1_code_i = 7'(nc);
        apply_i   = 1'b1;
        @(negedge clk_i);
        apply_i   = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk_i);
        rst_ni = 1'b1;
        // R9: reset state at phase 0, default divide by 4 then 1
        chk(clk_o == 1'b1, "R9 out", clk_o, 1);
        chk(code_err_o == 1'b0, "R9 err", code_err_o, 0);
        run_pattern(4, 1, 0, 16, "R9 default pattern");

        // R7: frozen load with new codes (including an unused one) is ignored
        do_apply(1, 3);
        run_pattern(5, 4, 0, 23, "R8 start");
        freeze_i  = 1'b1;
        hs_code_i = 3'b100;
        n1_code_i = 7'd9;
        apply_i   = 1'b1;
        chk(clk_o == exp_out(5, 4, 23), "R7 frozen", clk_o, exp_out(5, 4, 23));
        @(negedge clk_i);
        apply_i = 1'b0;
        run_pattern(5, 4, 24, 40, "R7 frozen apply ignored");
        chk(code_err_o == 1'b0, "R5 frozen bad code not flagged", code_err_o, 0);
        freeze_i  = 1'b0;
        hs_code_i = 3'b010;
        n1_code_i = 7'd1;
        run_pattern(5, 4, 64, 40, "R7 codes without apply ignored");

        // R8: mid-period reload restarts both stages
        do_apply(1, 3);
        run_pattern(5, 4, 0, 13, "R8 mid restart");
        do_apply(1, 3);
        run_pattern(5, 4, 0, 40, "R8 restart again");

        // Sweep: every high-speed code against edge and rounding N1 codes
        for (int hc = 0; hc < 8; hc++) begin
            for (int k = 0; k < 8; k++) begin
                int nc;
                int hs;
                int n1;
                case (k)
                    0: nc = 0;   1: nc = 1;   2: nc = 2;   3: nc = 3;
                    4: nc = 4;   5: nc = 5;   6: nc = 126; default: nc = 127;
                endcase
                hs = exp_hs(hc);
                n1 = exp_n1(nc);
                do_apply(hc, nc);
                if (hc == 4 || hc == 6) bad_seen = 1;
                chk(code_err_o == bad_seen, "R4 R5 error flag", code_err_o, int'(bad_seen));
                if (hc == 4 || hc == 6)
                    run_pattern(hs, n1, 0, 2 * hs * n1, "R4 unused code as 11");
                else if (nc != 0 && (nc % 2) == 0)
                    run_pattern(hs, n1, 0, 2 * hs * n1, "R1 R3 rounded ratio");
                else
                    run_pattern(hs, n1, 0, 2 * hs * n1, "R1 R2 R6 ratio and duty");
            end
        end

        // R5: valid load keeps the flag; R9: reset clears it
        do_apply(0, 0);
        chk(code_err_o == 1'b1, "R5 sticky after valid load", code_err_o, 1);
        rst_ni = 1'b0;
        @(negedge clk_i);
        rst_ni = 1'b1;
        chk(code_err_o == 1'b0, "R9 reset clears err", code_err_o, 0);
        run_pattern(4, 1, 0, 12, "R9 pattern after reset");

        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk_i);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", WATCHDOG_CYCLES, 0);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule